// File: doc/BRIEF.md
# Delayed-Transfer Program Counter Sequencer

This block keeps the fetch address of a 32-bit RISC core whose control transfers take effect one instruction late: the instruction after a branch or jump always runs before the target is fetched. Each retired instruction is presented for one cycle with `stepEn` high. With it come the decoded transfer kind, the two register operand values, the 16-bit branch offset, the 26-bit jump index, the raw rt field and a link destination index. The block answers in the same cycle with a taken flag and an optional link register write. At the clock edge it advances the fetch address.

Internally there are two address registers: the address of the instruction being stepped, and the address that follows it. A taken transfer moves the following address into the current one, so the delay-slot instruction runs next. It also parks the computed target as the following address. Relative branch targets are therefore measured from the delay-slot address. Direct jump targets take their upper bits from that same address.

Top module: `pc_delay_seq`

## Requirements
- R1: While `rstN` is low the fetch address is 0. The first step after reset with no transfer moves it to 4.
- R2: A step with no taken transfer advances the fetch address by 4. A cycle with `stepEn` low leaves the fetch address unchanged and produces no taken flag and no link write.
- R3: After a step with a taken transfer at address A, the next fetch address is A+4 (the delay slot). The step after that fetches the target. `branchTaken` is high only in the cycle of a stepped, taken transfer.
- R4: The conditional branch target for an instruction at A is A+4 plus the sign-extended 16-bit offset shifted left by 2, modulo 2^32.
- R5: `xferKind` encodings: 0 none, 1 branch if equal, 2 branch if not equal, 3 branch if source ≤ 0, 4 branch if source > 0, 5 sign-test group, 6 jump, 7 jump and link, 8 register jump, 9 register jump and link. Values 10 to 15 act as none. Equality compares `srcVal` with `cmpVal`. The sign tests treat `srcVal` as two's complement.
- R6: For kind 5, `rtField` bit 0 = 1 branches when source ≥ 0, and bit 0 = 0 branches when source < 0.
- R7: A jump (kind 6 or 7) at A is always taken, with target {bits 31:28 of A+4, `jumpIndex`, 2'b00}.
- R8: A register jump (kind 8 or 9) is always taken, with target `srcVal`.
- R9: The link value is A+8. Kind 7 writes register 31. Kind 9 writes register `linkDest`.
- R10: Kind 5 with `rtField` equal to 0x10 or 0x11 writes A+8 to register 31 whether or not the branch is taken.
- R11: A link write addressed to register 0 is not issued (`linkWrEn` stays low).
- R12: A transfer stepped in a delay slot is ignored. It produces no taken flag and no link write, and the pending target is fetched next, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | One instruction retires this cycle |
| xferKind | input | 4 | Decoded control-transfer kind (see R5) |
| rtField | input | 5 | Raw rt field, used by the sign-test group |
| srcVal | input | 32 | Source register value |
| cmpVal | input | 32 | Second register value for equality tests |
| brOffset | input | 16 | Signed branch word offset |
| jumpIndex | input | 26 | Direct jump word index |
| linkDest | input | 5 | Destination register of a register jump and link |
| fetchAddr | output | 32 | Address of the instruction to step next |
| branchTaken | output | 1 | Stepped transfer is taken |
| linkWrEn | output | 1 | Link write valid this cycle |
| linkWrIdx | output | 5 | Link write register index |
| linkWrData | output | 32 | Link write value |

## Verification
The hardest situation to reach is a transfer sitting in a delay slot. Only a taken transfer followed directly by another transfer exposes it, and a linking sign-test there must lose its otherwise unconditional link. Directed steps place a jump, and then a linking sign-test, straight after taken transfers. They also reach the upper address bits through a register jump to 0xF0000000, so that a following direct jump must keep those bits. Random steps mix kinds with operands drawn from zero, minus one and equal pairs, and idle cycles are interleaved, so back-to-back transfers and boundary sign cases recur many times.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    XK_NONE      = 4'd0,
    XK_EQ        = 4'd1,
    XK_NE        = 4'd2,
    XK_LEZ       = 4'd3,
    XK_GTZ       = 4'd4,
    XK_SIGN      = 4'd5,
    XK_JUMP      = 4'd6,
    XK_JUMP_LINK = 4'd7,
    XK_JREG      = 4'd8,
    XK_JREG_LINK = 4'd9
  } xfer_kind_e;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgt_sel_e;

  typedef struct packed {
    logic     advance;
    logic     capture;
    tgt_sel_e tgtSel;
  } seq_strobe_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepEn,
  input  logic [3:0]           xferKind,
  input  logic [REG_IDX_W-1:0] rtField,
  input  logic [XLEN-1:0]      srcVal,
  input  logic [XLEN-1:0]      cmpVal,
  input  logic [REG_IDX_W-1:0] linkDest,
  output seq_strobe_t          strb,
  output logic                 branchTaken,
  output logic                 linkWrEn,
  output logic [REG_IDX_W-1:0] linkWrIdx
);

  localparam logic [REG_IDX_W-2:0] SIGN_LINK_HI = (REG_IDX_W-1)'(1) << (REG_IDX_W-2);
  localparam logic [REG_IDX_W-1:0] LINK_IDX     = REG_IDX_W'(LINK_REG);

  xfer_kind_e           kind;
  logic                 pendingQ;
  logic                 isXfer;
  logic                 condMet;
  logic                 linkReq;
  logic [REG_IDX_W-1:0] idxSel;
  tgt_sel_e             tgtSel;
  logic                 srcNeg;
  logic                 srcZero;
  logic                 active;

  assign kind    = xfer_kind_e'(xferKind);
  assign srcNeg  = srcVal[XLEN-1];
  assign srcZero = (srcVal == '0);
  assign active  = stepEn && !pendingQ;

  always_comb begin
    isXfer  = 1'b0;
    condMet = 1'b0;
    linkReq = 1'b0;
    idxSel  = LINK_IDX;
    tgtSel  = TGT_REL;
    case (kind)
      XK_EQ: begin
        isXfer  = 1'b1;
        condMet = (srcVal == cmpVal);
      end
      XK_NE: begin
        isXfer  = 1'b1;
        condMet = (srcVal != cmpVal);
      end
      XK_LEZ: begin
        isXfer  = 1'b1;
        condMet = srcNeg || srcZero;
      end
      XK_GTZ: begin
        isXfer  = 1'b1;
        condMet = !srcNeg && !srcZero;
      end
      XK_SIGN: begin
        isXfer  = 1'b1;
        condMet = rtField[0] ? !srcNeg : srcNeg;
        linkReq = (rtField[REG_IDX_W-1:1] == SIGN_LINK_HI);
      end
      XK_JUMP: begin
        isXfer  = 1'b1;
        condMet = 1'b1;
        tgtSel  = TGT_ABS;
      end
      XK_JUMP_LINK: begin
        isXfer  = 1'b1;
        condMet = 1'b1;
        linkReq = 1'b1;
        tgtSel  = TGT_ABS;
      end
      XK_JREG: begin
        isXfer  = 1'b1;
        condMet = 1'b1;
        tgtSel  = TGT_REG;
      end
      XK_JREG_LINK: begin
        isXfer  = 1'b1;
        condMet = 1'b1;
        linkReq = 1'b1;
        idxSel  = linkDest;
        tgtSel  = TGT_REG;
      end
      default: begin
        isXfer = 1'b0;
      end
    endcase
  end

  always_comb begin
    strb.advance = stepEn;
    strb.capture = active && isXfer && condMet;
    strb.tgtSel  = tgtSel;
  end

  assign branchTaken = active && isXfer && condMet;
  assign linkWrEn    = active && linkReq && (idxSel != '0);
  assign linkWrIdx   = idxSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (stepEn) begin
      pendingQ <= active && isXfer && condMet;
    end
  end

endmodule

// File: rtl/pcseq_dpath.sv
module pcseq_dpath
  import pcseq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strb,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [IDX_W-1:0] jumpIndex,
  output logic [XLEN-1:0]  fetchAddr,
  output logic [XLEN-1:0]  linkWrData
);

  localparam int            SEXT_W  = XLEN - OFF_W - 2;
  localparam int            HI_W    = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] WORD  = XLEN'(4);
  localparam logic [XLEN-1:0] PAIR  = XLEN'(8);
  localparam logic [XLEN-1:0] PC0   = XLEN'(RESET_PC);

  logic [XLEN-1:0] pcQ;
  logic [XLEN-1:0] nextPcQ;
  logic [XLEN-1:0] relTgt;
  logic [XLEN-1:0] absTgt;
  logic [XLEN-1:0] tgt;

  assign relTgt = nextPcQ + {{SEXT_W{brOffset[OFF_W-1]}}, brOffset, 2'b00};
  assign absTgt = {nextPcQ[XLEN-1 -: HI_W], jumpIndex, 2'b00};

  always_comb begin
    case (strb.tgtSel)
      TGT_ABS: tgt = absTgt;
      TGT_REG: tgt = srcVal;
      default: tgt = relTgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= PC0;
      nextPcQ <= PC0 + WORD;
    end else if (strb.advance) begin
      pcQ <= nextPcQ;
      if (strb.capture) begin
        nextPcQ <= tgt;
      end else begin
        nextPcQ <= nextPcQ + WORD;
      end
    end
  end

  assign fetchAddr  = pcQ;
  assign linkWrData = pcQ + PAIR;

endmodule

// File: rtl/pc_delay_seq.sv
module pc_delay_seq
  import pcseq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int OFF_W     = 16,
  parameter int IDX_W     = 26,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31,
  parameter int RESET_PC  = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepEn,
  input  logic [3:0]           xferKind,
  input  logic [REG_IDX_W-1:0] rtField,
  input  logic [XLEN-1:0]      srcVal,
  input  logic [XLEN-1:0]      cmpVal,
  input  logic [OFF_W-1:0]     brOffset,
  input  logic [IDX_W-1:0]     jumpIndex,
  input  logic [REG_IDX_W-1:0] linkDest,
  output logic [XLEN-1:0]      fetchAddr,
  output logic                 branchTaken,
  output logic                 linkWrEn,
  output logic [REG_IDX_W-1:0] linkWrIdx,
  output logic [XLEN-1:0]      linkWrData
);

  seq_strobe_t strb;

  pcseq_ctrl #(
    .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .xferKind(xferKind),
    .rtField(rtField), .srcVal(srcVal), .cmpVal(cmpVal), .linkDest(linkDest),
    .strb(strb), .branchTaken(branchTaken), .linkWrEn(linkWrEn),
    .linkWrIdx(linkWrIdx)
  );

  pcseq_dpath #(
    .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .RESET_PC(RESET_PC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .srcVal(srcVal),
    .brOffset(brOffset), .jumpIndex(jumpIndex),
    .fetchAddr(fetchAddr), .linkWrData(linkWrData)
  );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 stepEn,
  input logic [XLEN-1:0]      fetchAddr,
  input logic                 branchTaken,
  input logic                 linkWrEn,
  input logic [REG_IDX_W-1:0] linkWrIdx,
  input logic [XLEN-1:0]      linkWrData
);

  // R1: first cycle out of reset shows address zero
  p_reset_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> fetchAddr == '0);

  // R2: idle cycle holds the address
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(fetchAddr));

  // R3: taken flag only on a step
  p_taken_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> stepEn);

  // R3: delay slot follows a taken transfer
  p_delay_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |=> fetchAddr == $past(fetchAddr) + XLEN'(4));

  // R12: no taken transfer straight after a taken one
  p_single_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |=> !branchTaken);

  // R11: register zero never written
  p_no_zero_link_r11: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> linkWrIdx != '0);

  // R9: link value relative to the stepped address
  p_link_value_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> linkWrData == fetchAddr + XLEN'(8));

endmodule

bind pc_delay_seq pcseq_checker #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .stepEn(stepEn), .fetchAddr(fetchAddr),
  .branchTaken(branchTaken), .linkWrEn(linkWrEn), .linkWrIdx(linkWrIdx),
  .linkWrData(linkWrData)
);

// File: tb/pc_delay_seq_test.sv
module pc_delay_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [3:0]  xferKind = '0;
  logic [4:0]  rtField = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] cmpVal = '0;
  logic [15:0] brOffset = '0;
  logic [25:0] jumpIndex = '0;
  logic [4:0]  linkDest = '0;
  logic [31:0] fetchAddr;
  logic        branchTaken;
  logic        linkWrEn;
  logic [4:0]  linkWrIdx;
  logic [31:0] linkWrData;

  always #2 clk = ~clk;

  pc_delay_seq uut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .xferKind(xferKind),
    .rtField(rtField), .srcVal(srcVal), .cmpVal(cmpVal), .brOffset(brOffset),
    .jumpIndex(jumpIndex), .linkDest(linkDest), .fetchAddr(fetchAddr),
    .branchTaken(branchTaken), .linkWrEn(linkWrEn), .linkWrIdx(linkWrIdx),
    .linkWrData(linkWrData)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mPc;
  logic [31:0] mNext;
  bit          mPend;

  function automatic bit mCond(int k, logic [4:0] rt, logic [31:0] s, logic [31:0] c);
    case (k)
      1: return s == c;
      2: return s != c;
      3: return $signed(s) <= 32'sd0;
      4: return $signed(s) > 32'sd0;
      5: return rt[0] ? ($signed(s) >= 32'sd0) : ($signed(s) < 32'sd0);
      6, 7, 8, 9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [4:0] mLinkIdx(int k, logic [4:0] rt, logic [4:0] ld);
    case (k)
      5: return (rt == 5'h10 || rt == 5'h11) ? 5'd31 : 5'd0;
      7: return 5'd31;
      9: return ld;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] mTarget(int k, logic [15:0] off, logic [25:0] idx,
                                          logic [31:0] s, logic [31:0] nxt);
    if (k >= 1 && k <= 5) return nxt + {{14{off[15]}}, off, 2'b00};
    if (k == 6 || k == 7) return {nxt[31:28], idx, 2'b00};
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doStep(string tag, bit en, int k, logic [4:0] rt, logic [31:0] s,
                        logic [31:0] c, logic [15:0] off, logic [25:0] idx,
                        logic [4:0] ld);
    bit          expTaken;
    logic [4:0]  li;
    logic [31:0] tgt;
    @(negedge clk);
    chk({tag, " fetch"}, fetchAddr, mPc);
    stepEn = en; xferKind = 4'(k); rtField = rt; srcVal = s; cmpVal = c;
    brOffset = off; jumpIndex = idx; linkDest = ld;
    #1;
    expTaken = en && !mPend && mCond(k, rt, s, c);
    li = (en && !mPend) ? mLinkIdx(k, rt, ld) : 5'd0;
    chk({tag, " taken"}, {31'b0, branchTaken}, {31'b0, expTaken});
    chk({tag, " linkEn"}, {31'b0, linkWrEn}, {31'b0, (li != 5'd0)});
    if (li != 5'd0) begin
      chk({tag, " linkIdx"}, {27'b0, linkWrIdx}, {27'b0, li});
      chk({tag, " linkData"}, linkWrData, mPc + 32'd8);
    end
    @(posedge clk);
    if (en) begin
      tgt = mTarget(k, off, idx, s, mNext);
      mPc = mNext;
      if (expTaken) begin
        mNext = tgt;
        mPend = 1'b1;
      end else begin
        mNext = mNext + 32'd4;
        mPend = 1'b0;
      end
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mPc = 32'd0; mNext = 32'd4; mPend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset fetch", fetchAddr, 32'd0);
    rstN = 1'b1;
    // R1: first plain step goes to 4
    doStep("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    // R2: idle cycles hold
    doStep("R2 idle", 0, 1, 0, 5, 5, 0, 0, 0);
    doStep("R2 idle", 0, 7, 0, 5, 5, 0, 0, 0);
    // R4: backward branch, target = 4+4-4 = 4
    doStep("R4 beq", 1, 1, 0, 32'd5, 32'd5, 16'hFFFF, 0, 0);
    // R12: jump in delay slot ignored; R3 checks fetch 8 here
    doStep("R12 R3 slot jump", 1, 6, 0, 0, 0, 0, 26'd100, 0);
    // R10: linking sign-test not taken still links
    doStep("R10 R4", 1, 5, 5'h10, 32'd5, 0, 16'd3, 0, 0);
    // R11: register jump and link to reg 0
    doStep("R11 R8", 1, 9, 0, 32'hF000_0000, 0, 0, 0, 5'd0);
    doStep("R3 slot", 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 R9: direct jump keeps top bits
    doStep("R8 R7 R9", 1, 7, 0, 0, 0, 0, 26'h10, 0);
    // R12: linking sign-test in delay slot
    doStep("R12 link slot", 1, 5, 5'h11, 32'd0, 0, 16'd8, 0, 0);
    // R9: register jump and link to reg 7
    doStep("R7 R9 jrl", 1, 9, 0, 32'h100, 0, 0, 0, 5'd7);
    doStep("R3 slot", 1, 0, 0, 0, 0, 0, 0, 0);
    // R5: boundaries at zero
    doStep("R8 R5 gtz0", 1, 4, 0, 32'd0, 0, 16'd4, 0, 0);
    doStep("R5 lez0", 1, 3, 0, 32'd0, 0, 16'd4, 0, 0);
    doStep("R3 slot", 1, 0, 0, 0, 0, 0, 0, 0);
    doStep("R5 bne", 1, 2, 0, 32'd1, 32'd2, 16'h8000, 0, 0);
    doStep("R3 slot", 1, 0, 0, 0, 0, 0, 0, 0);
    // R6: bit0=1 with most negative source not taken, bit0=0 taken
    doStep("R4 R6 ge", 1, 5, 5'h01, 32'h8000_0000, 0, 16'd2, 0, 0);
    doStep("R6 lt", 1, 5, 5'h00, 32'h8000_0000, 0, 16'd2, 0, 0);
    doStep("R3 slot", 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] c;
      logic [31:0] s;
      logic [4:0]  rt;
      int          pick;
      c = ($urandom % 2 == 0) ? 32'($urandom % 3) : $urandom;
      pick = $urandom % 4;
      s = (pick == 0) ? 32'd0 : (pick == 1) ? 32'hFFFF_FFFF : (pick == 2) ? c : $urandom;
      rt = ($urandom % 3 == 0) ? (5'h10 | 5'($urandom % 2)) : 5'($urandom % 32);
      doStep("R5 R6 rand", ($urandom % 5) != 0, $urandom % 11, rt, s, c,
             16'($urandom), 26'($urandom), 5'($urandom % 32));
    end
    @(negedge clk);
    chk("R2 final fetch", fetchAddr, mPc);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule